// File: doc/BRIEF.md
# NMI source aggregation controller

This block gathers error events from a bus bridge and its I/O subsystem and turns them into a single non-maskable interrupt request. Five hardware sources feed it: a channel-check event from the serial interrupt logic, a signalled-system-error event, and three parity-error pulses. The parity pulses are grouped by the master that ran the failing cycle: the upstream hub link, the audio/disk/USB masters, and the LPC/legacy DMA masters. Each source has its own enable bit and its own sticky status bit. A status bit is set only when its enable is 1 and is cleared by software writing 1 to it.

The recorded statuses are ORed with a software "raise now" bit. The result is gated by a global enable and then registered onto either the NMI line or the SMI line, as a routing bit selects. A small register port gives software access to the enables, the statuses and the control bits.

Top module: `nmi_aggregator`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears every enable, status and control bit, and drives `nmi_o` and `smi_o` to 0.
- R2: A one-cycle event pulse on a source whose enable bit is 1 sets that source's status bit at the same edge. The bit positions, used in both the enable register (address 0) and the status register (address 1), are: 0 channel check, 1 system error, 2 hub-link parity, 3 audio/disk/USB parity, 4 LPC/DMA parity.
- R3: An event pulse on a source whose enable bit is 0 leaves that source's status bit at 0.
- R4: Status bits are sticky. A status bit stays set until a write to address 1 with a 1 in its position. A 0 written in that position leaves it unchanged.
- R5: Writing 0 to an enable bit stops further setting of that status bit but does not clear a status bit that is already set.
- R6: The output request is registered. One edge after the global enable (address 2 bit 0) is 1 and any status bit or the force bit is 1, the selected output goes high. It goes low one edge after the last status is cleared, the force bit is cleared, or the global enable is cleared.
- R7: With the routing bit (address 2 bit 1) at 1 the request appears on `smi_o` instead of `nmi_o`. The two outputs are never high together.
- R8: The force bit (address 2 bit 2) raises the request with no status bit set, subject to the global enable.
- R9: With the global enable at 0 both outputs stay low, while enabled events still set their status bits.
- R10: When an event sets a status bit in the same cycle as a write-1-to-clear of that bit, the bit ends up set. A clear of other bits in that cycle still takes effect.
- R11: Reads are combinational on `rd_data`. Address 0 returns the enables in bits 4:0, address 1 the statuses in bits 4:0, address 2 {force, route, global} in bits 2:0, and address 3 returns 0. All unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| chan_chk_evt | input | 1 | Channel-check event pulse |
| sys_err_evt | input | 1 | Signalled-system-error event pulse |
| hub_par_evt | input | 1 | Hub-link parity error pulse |
| dev_par_evt | input | 1 | Parity error pulse from an audio, disk or USB master cycle |
| lpc_par_evt | input | 1 | Parity error pulse from an LPC or legacy DMA master cycle |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address |
| wr_data | input | DATA_W | Register write data |
| rd_data | output | DATA_W | Register read data |
| nmi_o | output | 1 | Non-maskable interrupt request, level |
| smi_o | output | 1 | System management interrupt request, level |

## Verification
Two functions can meet in the same cycle: a hardware event setting a status bit, and a software write-1-to-clear aimed at the status register. The bench provokes this by driving an event pulse and the clear write in the same cycle. It does this once for the same bit and once for a different bit. It then reads the status register back and expects the event to survive and the other bit to clear. A checker property also requires that no status bit falls unless a clear for it was written, and that none rises unless its enable was set.

// File: rtl/nmi_aggregator.sv
module nmi_aggregator #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chan_chk_evt,
  input  logic              sys_err_evt,
  input  logic              hub_par_evt,
  input  logic              dev_par_evt,
  input  logic              lpc_par_evt,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              nmi_o,
  output logic              smi_o
);
  localparam int SRC_N = 5;
  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(2);

  logic [SRC_N-1:0] en_q, sts_q, evt, clr;
  logic             glb_q, route_q, force_q, req;

  assign evt = {lpc_par_evt, dev_par_evt, hub_par_evt, sys_err_evt, chan_chk_evt};
  assign clr = (wr_en && addr == A_STS) ? wr_data[SRC_N-1:0] : '0;
  assign req = glb_q & ((|sts_q) | force_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      sts_q   <= '0;
      glb_q   <= 1'b0;
      route_q <= 1'b0;
      force_q <= 1'b0;
      nmi_o   <= 1'b0;
      smi_o   <= 1'b0;
    end else begin
      sts_q <= (sts_q & ~clr) | (evt & en_q);
      if (wr_en && addr == A_EN) en_q <= wr_data[SRC_N-1:0];
      if (wr_en && addr == A_CTL) begin
        glb_q   <= wr_data[0];
        route_q <= wr_data[1];
        force_q <= wr_data[2];
      end
      nmi_o <= req & ~route_q;
      smi_o <= req & route_q;
    end
  end

  always_comb begin
    case (addr)
      A_EN:    rd_data = DATA_W'(en_q);
      A_STS:   rd_data = DATA_W'(sts_q);
      A_CTL:   rd_data = DATA_W'({force_q, route_q, glb_q});
      default: rd_data = '0;
    endcase
  end
endmodule

module nmi_aggregator_chk (
  input logic       clk,
  input logic       rst,
  input logic [4:0] en,
  input logic [4:0] sts,
  input logic [4:0] clr,
  input logic       glb,
  input logic       nmi,
  input logic       smi
);
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (sts == 5'd0 && !nmi && !smi));
  a_r3_no_set_when_disabled: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((sts & ~$past(sts) & ~$past(en)) == 5'd0));
  a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(sts) & ~$past(clr) & ~sts) == 5'd0));
  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst) !(nmi && smi));
  a_r9_global_mask: assert property (@(posedge clk) disable iff (rst) !glb |=> (!nmi && !smi));
endmodule

bind nmi_aggregator nmi_aggregator_chk u_chk (
  .clk(clk), .rst(rst), .en(en_q), .sts(sts_q), .clr(clr),
  .glb(glb_q), .nmi(nmi_o), .smi(smi_o)
);

// File: tb/sim_nmi_aggregator.sv
module sim_nmi_aggregator;
  logic clk = 1'b0, rst = 1'b1;
  logic chan_chk_evt = 0, sys_err_evt = 0, hub_par_evt = 0, dev_par_evt = 0, lpc_par_evt = 0;
  logic wr_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic nmi_o, smi_o;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  nmi_aggregator u0 (.*);

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic set_evt(input logic [4:0] m);
    {lpc_par_evt, dev_par_evt, hub_par_evt, sys_err_evt, chan_chk_evt} = m;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; #0.5; d = rd_data;
  endtask

  task automatic pulse(input logic [4:0] m);
    @(negedge clk); set_evt(m);
    @(negedge clk); set_evt(5'd0);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int a = 0; a < 4; a++) begin rd(2'(a), d); chk("R1", "reg after reset", d, 8'h00); end
    chk("R1", "nmi after reset", {7'd0, nmi_o}, 8'h00);
    chk("R1", "smi after reset", {7'd0, smi_o}, 8'h00);
  endtask

  task automatic t_each_source;
    logic [7:0] d;
    wr(0, 8'h1F); wr(2, 8'h01);
    for (int i = 0; i < 5; i++) begin
      pulse(5'(1 << i));
      rd(1, d); chk("R2", "status of single source", d, 8'(1 << i));
      chk("R6", "nmi one edge later, not yet", {7'd0, nmi_o}, 8'h00);
      @(negedge clk);
      chk("R6", "nmi raised", {7'd0, nmi_o}, 8'h01);
      wr(1, 8'h1F);
      chk("R6", "nmi still high at clear edge", {7'd0, nmi_o}, 8'h01);
      @(negedge clk);
      chk("R6", "nmi dropped after clear", {7'd0, nmi_o}, 8'h00);
    end
  endtask

  task automatic t_masked;
    logic [7:0] d;
    wr(0, 8'h04);
    pulse(5'h1F);
    rd(1, d); chk("R3", "only enabled source recorded", d, 8'h04);
  endtask

  task automatic t_sticky;
    logic [7:0] d;
    repeat (4) @(negedge clk);
    rd(1, d); chk("R4", "status held", d, 8'h04);
    wr(1, 8'h1B);
    rd(1, d); chk("R4", "write 0 keeps bit", d, 8'h04);
    wr(1, 8'h04);
    rd(1, d); chk("R4", "write 1 clears bit", d, 8'h00);
  endtask

  task automatic t_enable_clear;
    logic [7:0] d;
    wr(0, 8'h02); pulse(5'h02);
    wr(0, 8'h00);
    rd(1, d); chk("R5", "status kept after enable cleared", d, 8'h02);
    @(negedge clk);
    chk("R5", "nmi kept after enable cleared", {7'd0, nmi_o}, 8'h01);
    pulse(5'h01);
    rd(1, d); chk("R5", "disabled source not recorded", d, 8'h02);
  endtask

  task automatic t_global;
    logic [7:0] d;
    wr(2, 8'h00);
    @(negedge clk);
    chk("R9", "nmi masked", {7'd0, nmi_o}, 8'h00);
    chk("R9", "smi masked", {7'd0, smi_o}, 8'h00);
    wr(0, 8'h10); pulse(5'h10);
    rd(1, d); chk("R9", "status still set while masked", d, 8'h12);
    @(negedge clk);
    chk("R9", "nmi masked with status", {7'd0, nmi_o}, 8'h00);
  endtask

  task automatic t_route;
    wr(2, 8'h03);
    @(negedge clk);
    chk("R7", "smi when routed", {7'd0, smi_o}, 8'h01);
    chk("R7", "nmi low when routed", {7'd0, nmi_o}, 8'h00);
    wr(2, 8'h01);
    @(negedge clk);
    chk("R7", "nmi back when unrouted", {6'd0, smi_o, nmi_o}, 8'h01);
  endtask

  task automatic t_force;
    logic [7:0] d;
    wr(1, 8'h1F);
    @(negedge clk);
    chk("R8", "nmi low with no status", {7'd0, nmi_o}, 8'h00);
    wr(2, 8'h05);
    @(negedge clk);
    chk("R8", "forced nmi", {7'd0, nmi_o}, 8'h01);
    rd(1, d); chk("R8", "force sets no status", d, 8'h00);
    wr(2, 8'h04);
    @(negedge clk);
    chk("R8", "force gated by global", {7'd0, nmi_o}, 8'h00);
  endtask

  task automatic t_collide;
    logic [7:0] d;
    wr(0, 8'h1F);
    pulse(5'h09);
    @(negedge clk); wr_en = 1; addr = 1; wr_data = 8'h09; set_evt(5'h01);
    @(negedge clk); wr_en = 0; set_evt(5'h00);
    rd(1, d); chk("R10", "set wins over clear, other bit cleared", d, 8'h01);
  endtask

  task automatic t_map;
    logic [7:0] d;
    wr(0, 8'hFF); rd(0, d); chk("R11", "enable readback", d, 8'h1F);
    wr(2, 8'hFF); rd(2, d); chk("R11", "control readback", d, 8'h07);
    rd(3, d); chk("R11", "unused address", d, 8'h00);
    rd(1, d); chk("R11", "status readback", d, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset; t_each_source; t_masked; t_sticky; t_enable_clear;
    t_global; t_route; t_force; t_collide; t_map;
    wr(1, 8'h00);
    rst = 1; @(negedge clk); rst = 0;
    t_reset;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule